// File: doc/BRIEF.md
# Double-Buffered PWM Duty Generator

This block drives one pulse-width-modulated output from a 5-bit duty code. Each output period holds 32 slots. A slot is one tick of an enable that a prescaler derives from the system clock, so a period lasts `32 * PRESCALE` clocks. The output is high in slot `n` when `n` is below the active code. Code 0 therefore keeps the line low, and each step adds 1/32 of the period. A separate full-on command holds the line high for the whole period, which no 5-bit code can do.

The host writes a code or the full-on command through a single-cycle write strobe. The value lands in a shadow register. It moves to the active register only where the slot counter wraps from 31 to 0, so every period runs on one setting from start to end.

A two-state update machine tracks whether a staged value is waiting:
- `UPD_IDLE`: nothing is staged. The transition *stage* (write strobe) leads to `UPD_PENDING`.
- `UPD_PENDING`: a staged value is waiting. The transition *commit* (boundary with no write in the same cycle) copies shadow to active, pulses the status output and returns to `UPD_IDLE`.
- A boundary that coincides with a write commits the older staged value and stays in `UPD_PENDING`. The new value then commits at the following boundary.

Top module: `pwm_duty_gen`

## Requirements
- R1: While reset is held and after it is released, `pwm_out` and `update_pulse` are 0. The active setting is code 0 with full-on off, so the first period after reset has no high clocks.
- R2: With the active code `c` (0..31) and full-on off, `pwm_out` is high for exactly `c * PRESCALE` clocks of each `32 * PRESCALE`-clock period, starting at the period's first clock. Code 0 gives no high clocks.
- R3: With full-on active, `pwm_out` is high on every clock of the period (`32 * PRESCALE` clocks).
- R4: A write changes only the shadow. The output keeps the old setting until the next period boundary, where the slot counter wraps from 31 to 0.
- R5: After a write, the new setting is in force within two output periods (at most `64 * PRESCALE` clocks).
- R6: Writing a normal code (`wr_full_on` = 0) clears full-on mode, and this too takes effect only at a period boundary.
- R7: `update_pulse` is high for one clock, the first clock of a period, at each boundary where a staged value is committed. It never goes high at a boundary with nothing staged.
- R8: When several writes arrive before one boundary, the last one is the value committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle strobe that stages `wr_code` / `wr_full_on` |
| wr_full_on | input | 1 | 1 stages the full-on command, 0 stages the normal code |
| wr_code | input | CODE_W | Duty code to stage (5 bits by default) |
| pwm_out | output | 1 | PWM output |
| update_pulse | output | 1 | One-clock pulse when a staged value becomes active |

## Verification
The assertions assume `wr_en` is a clean synchronous strobe. They also assume a period is much longer than one clock, so a commit pulse can never follow another commit pulse directly. The stimulus keeps to this because every write is a single-cycle pulse launched on a falling clock edge. Most writes come just after a period boundary, so a whole period passes before they commit. One directed test writes in the middle of a period on purpose, to show that the output holds its old level until the wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        UPD_IDLE    = 1'b0,
        UPD_PENDING = 1'b1
    } upd_state_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(PRESCALE);
            localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
            logic [CW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (!rst_n)           div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                  div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [CODE_W-1:0] slot,
    output logic              wrap
);
    logic [CODE_W-1:0] slot_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    slot_q <= '0;
        else if (tick) slot_q <= slot_q + 1'b1;
    end
    assign slot = slot_q;
    assign wrap = tick && (slot_q == {CODE_W{1'b1}});
endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank
    import pwm_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_full_on,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wrap,
    output logic [CODE_W-1:0] act_code,
    output logic              act_full,
    output logic              commit,
    output upd_state_e        state
);
    upd_state_e        state_q, state_d;
    logic [CODE_W-1:0] shd_code_q, act_code_q;
    logic              shd_full_q, act_full_q, commit_q;
    logic              do_commit;

    assign do_commit = wrap && (state_q == UPD_PENDING);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:    if (wr_en)          state_d = UPD_PENDING;
            UPD_PENDING: if (wrap && !wr_en) state_d = UPD_IDLE;
            default:                         state_d = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_code_q <= '0;
            shd_full_q <= 1'b0;
            act_code_q <= '0;
            act_full_q <= 1'b0;
            commit_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                shd_code_q <= wr_code;
                shd_full_q <= wr_full_on;
            end
            if (do_commit) begin
                act_code_q <= shd_code_q;
                act_full_q <= shd_full_q;
            end
            commit_q <= do_commit;
        end
    end

    assign act_code = act_code_q;
    assign act_full = act_full_q;
    assign commit   = commit_q;
    assign state    = state_q;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] slot,
    input  logic [CODE_W-1:0] act_code,
    input  logic              act_full,
    output logic              level
);
    assign level = act_full || (slot < act_code);
endmodule

// File: rtl/pwm_duty_gen.sv
module pwm_duty_gen
    import pwm_pkg::*;
#(
    parameter int CODE_W   = 5,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_full_on,
    input  logic [CODE_W-1:0] wr_code,
    output logic              pwm_out,
    output logic              update_pulse
);
    logic              tick, wrap;
    logic [CODE_W-1:0] slot, act_code;
    logic              act_full;
    upd_state_e        upd_state;

    pwm_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pwm_period_ctr #(.CODE_W(CODE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .slot(slot), .wrap(wrap)
    );

    pwm_duty_bank #(.CODE_W(CODE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full_on(wr_full_on),
        .wr_code(wr_code), .wrap(wrap), .act_code(act_code),
        .act_full(act_full), .commit(update_pulse), .state(upd_state)
    );

    pwm_compare #(.CODE_W(CODE_W)) u_cmp (
        .slot(slot), .act_code(act_code), .act_full(act_full), .level(pwm_out)
    );
endmodule

// File: rtl/pwm_duty_gen_chk.sv
module pwm_duty_gen_chk
    import pwm_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              pwm_out,
    input logic              update_pulse,
    input logic [CODE_W-1:0] slot,
    input logic [CODE_W-1:0] act_code,
    input logic              act_full,
    input upd_state_e        upd_state
);
    p_zero_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_full && act_code == '0) |-> !pwm_out);

    p_full_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_full |-> pwm_out);

    p_hold_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !update_pulse |-> ($stable(act_code) && $stable(act_full)));

    p_stage_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (upd_state == UPD_PENDING));

    p_pulse_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |-> (slot == '0));

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |=> !update_pulse);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!update_pulse && !pwm_out));
endmodule

bind pwm_duty_gen pwm_duty_gen_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pwm_out(pwm_out),
    .update_pulse(update_pulse), .slot(slot), .act_code(act_code),
    .act_full(act_full), .upd_state(upd_state)
);

// File: tb/pwm_duty_gen_tb.sv
`timescale 1ns/1ps
module pwm_duty_gen_tb;
    localparam int CODE_W   = 5;
    localparam int PRESCALE = 4;
    localparam int PERIOD   = 32 * PRESCALE;
    localparam int NVEC     = 7;
    // vector table: full-on flag, code, expected high clocks per period
    localparam int VEC_FULL [NVEC] = '{0, 0, 0, 0, 1, 0, 0};
    localparam int VEC_CODE [NVEC] = '{1, 15, 16, 31, 9, 4, 0};
    localparam int VEC_EXP  [NVEC] = '{4, 60, 64, 124, 128, 16, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_full_on = 1'b0;
    logic [CODE_W-1:0] wr_code = '0;
    logic pwm_out, update_pulse;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pwm_duty_gen #(.CODE_W(CODE_W), .PRESCALE(PRESCALE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full_on(wr_full_on),
        .wr_code(wr_code), .pwm_out(pwm_out), .update_pulse(update_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write(input bit full, input int code);
        @(negedge clk);
        wr_en = 1'b1; wr_full_on = full; wr_code = CODE_W'(code);
        @(negedge clk);
        wr_en = 1'b0; wr_full_on = 1'b0;
    endtask

    task automatic wait_update(output int lat);
        lat = 1;
        while (!update_pulse && lat < 4 * PERIOD) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic measure(output int hi);
        hi = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lat, hi, bad, pulses;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1 pwm in reset", int'(pwm_out), 0);
        check(update_pulse == 1'b0, "R1 pulse in reset", int'(update_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        measure(hi);
        check(hi == 0, "R1 first period low", hi, 0);

        // table walk: R2, R3, R5, R6 (entry 5 clears full-on set by entry 4)
        for (int v = 0; v < NVEC; v++) begin
            write(VEC_FULL[v] != 0, VEC_CODE[v]);
            wait_update(lat);
            check(update_pulse && lat <= 2 * PERIOD, "R5 latency", lat, 2 * PERIOD);
            measure(hi);
            check(hi == VEC_EXP[v], (VEC_FULL[v] != 0) ? "R3 full-on" :
                  (v == 5) ? "R6 full-on cleared" : "R2 duty", hi, VEC_EXP[v]);
        end

        // R7: no pulse at boundaries with nothing staged
        pulses = 0;
        for (int i = 0; i < 2 * PERIOD; i++) begin
            if (update_pulse) pulses++;
            @(negedge clk);
        end
        check(pulses == 0, "R7 no idle pulse", pulses, 0);

        // R7: pulse lasts one clock
        write(1'b0, 8);
        wait_update(lat);
        @(negedge clk);
        check(update_pulse == 1'b0, "R7 single-clock pulse", int'(update_pulse), 0);
        hi = 0;
        for (int i = 1; i < PERIOD; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
        check(hi == 8 * PRESCALE - 1, "R2 code 8", hi, 8 * PRESCALE - 1);

        // R4: write mid-period (slot 10, past code 8); output stays low until wrap
        repeat (40) @(negedge clk);
        write(1'b0, 24);
        bad = 0;
        lat = 0;
        while (!update_pulse && lat < 4 * PERIOD) begin
            if (pwm_out) bad++;
            @(negedge clk);
            lat++;
        end
        check(bad == 0, "R4 deferred to boundary", bad, 0);
        measure(hi);
        check(hi == 24 * PRESCALE, "R4 new duty after wrap", hi, 24 * PRESCALE);

        // R8: two writes before one boundary, last wins
        write(1'b0, 20);
        write(1'b0, 3);
        wait_update(lat);
        measure(hi);
        check(hi == 3 * PRESCALE, "R8 last write wins", hi, 3 * PRESCALE);

        // R6 again: full-on then normal code 0 turns output fully off
        write(1'b1, 0);
        wait_update(lat);
        measure(hi);
        check(hi == PERIOD, "R3 full-on with code 0", hi, PERIOD);
        write(1'b0, 0);
        wait_update(lat);
        measure(hi);
        check(hi == 0, "R6 clear to code 0", hi, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule